// File: doc/BRIEF.md
# Four-Channel Transceiver Management Register Bank

This block is the management register file of a four-channel serial transceiver. A station manager talks to it over a two-wire management bus that carries Clause 22 frames. The bus clock is the block's only clock, and the serial data line arrives as a separate input, output and output-enable. Every channel owns one basic control register. That register drives the channel's loopback, power-down and isolate controls. Two further registers hold one shared copy for the whole device, whichever channel they are reached through.

A frame names a 5-bit port address. Its top three bits must match a base-address input, and its low two bits pick the channel. Frames are honoured only while a strap input that selects Clause 22 framing is high. The control register mixes several kinds of bit:
- stored bits (loopback, power-down, isolate);
- bits that read as fixed constants whatever was written;
- a device-wide soft-reset bit that clears itself one bus clock after it is set.

There is no streaming data path. All pins are plain control or status levels, and the serial line has no back-pressure.

Top module: `mdio_phy_bank`

## Requirements
- R1: While `cl22_sel` is 0, frames are ignored: reads leave `mdio_oe` at 0 for the whole frame, and writes change no register or output.
- R2: Port address bits [1:0] select channel 0..3. Port address bits [4:2] must equal `phy_base`, otherwise the frame is ignored.
- R3: A frame begins with 32 ones, then start bits 0,1, then opcode (1,0 for read; 0,1 for write), then the 5-bit port address and the 5-bit register address, all MSB first. On a valid read, `mdio_oe` is 0 during the first turnaround bit and is 1 with `mdio_o`=0 during the second. It then stays 1 while 16 data bits go out MSB first, each changing after a rising edge, and returns to 0 afterwards.
- R4: Register 0 (control) reads 0x0140 after reset. Bits 13, 12, 9, 7 and 5..0 always read 0. Bits 8 and 6 always read 1. Bit 15 reads 0. So writing 0x7FFF reads back 0x4D40.
- R5: Control bit 14 is the channel's stored loopback bit, and it is what reads back. `loopback_o[ch]` is that bit ORed with `ext_loop_i[ch]`.
- R6: Control bit 11 drives `pdown_o[ch]` and bit 10 drives `isolate_o[ch]`. Both change only on a write to that channel's control register, or on a reset.
- R7: Registers 30 and 31 are 16-bit read/write and shared. A write through any channel is read back unchanged through every channel.
- R8: Writing 1 to control bit 15 on any channel raises `soft_rst_o` for exactly one clock, on the clock after the write. On the following clock every control register returns to 0x0140, registers 30 and 31 return to 0, and all channel outputs clear.
- R9: Reads of any register address other than 0, 30 and 31 return 0x0000. Writes to such addresses change nothing.
- R10: A frame preceded by fewer than 32 consecutive ones is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mdc | input | 1 | Management bus clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low device reset |
| cl22_sel | input | 1 | Strap: 1 enables Clause 22 frame handling |
| phy_base | input | 3 | Base value matched against port address bits [4:2] |
| mdio_i | input | 1 | Serial management data from the bus |
| mdio_o | output | 1 | Serial read data driven towards the bus |
| mdio_oe | output | 1 | Output enable for `mdio_o` |
| ext_loop_i | input | 4 | Per-channel external loopback request pins |
| loopback_o | output | 4 | Per-channel effective serial loopback enable |
| pdown_o | output | 4 | Per-channel power-down control |
| isolate_o | output | 4 | Per-channel isolate (parallel outputs disabled, inputs ignored) |
| soft_rst_o | output | 1 | One-clock device soft-reset pulse |

## Verification
The soft reset and the ordinary per-channel bits can be written by the same frame. Writing 0xC800 to channel 2 asks for loopback, power-down and reset in a single data word. The check is that reset wins: `soft_rst_o` must be high on exactly the one clock after the last data bit. After that, the power-down, isolate and loopback outputs must be clear, and every register must read its default, including the shared pair set up beforehand. A second overlap is the external loopback pin and the stored loopback bit driving the same output. The pin is set while the stored bit is clear, and the output and the read-back are compared separately.

// File: rtl/mdio_bank_pkg.sv
package mdio_bank_pkg;
  localparam int DW = 16;
  localparam int AW = 5;

  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;

  localparam logic [AW-1:0] REG_CTRL = 5'd0;
  localparam logic [AW-1:0] REG_G0   = 5'd30;
  localparam logic [AW-1:0] REG_G1   = 5'd31;

  // constant-one bits of the control word
  localparam logic [DW-1:0] CTRL_FIXED = 16'h0140;

  localparam int B_RST  = 15;
  localparam int B_LOOP = 14;
  localparam int B_PD   = 11;
  localparam int B_ISO  = 10;

  typedef enum logic [2:0] {
    FS_PRE, FS_ST, FS_HDR, FS_TA1, FS_TA2, FS_DAT
  } fs_e;
endpackage

// File: rtl/mdio_frame_rx.sv
module mdio_frame_rx
  import mdio_bank_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int BASE_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst,
  input  logic              strap_en,
  input  logic [BASE_W-1:0] base,
  input  logic              mdio_i,
  input  logic [DW-1:0]     rdata,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              wr_en,
  output logic [DW-1:0]     wdata,
  output logic [AW-1:0]     phy_q,
  output logic [AW-1:0]     reg_q
);
  localparam int PCW = $clog2(PRE_LEN + 1);
  localparam int HW  = 2 + 2 * AW;
  localparam int CW  = $clog2((DW > HW) ? DW : HW);
  localparam logic [PCW-1:0] PRE_FULL = PCW'(PRE_LEN);
  localparam logic [CW-1:0]  HDR_LAST = CW'(HW - 1);
  localparam logic [CW-1:0]  DAT_LAST = CW'(DW - 1);

  fs_e            state;
  logic [PCW-1:0] pre_cnt;
  logic [CW-1:0]  cnt;
  logic [HW-2:0]  hdr_q;
  logic [DW-1:0]  sh_q;
  logic           is_rd;

  logic [HW-1:0]  hdr_full;
  logic [1:0]     op;
  logic [AW-1:0]  phy_n;
  logic [AW-1:0]  reg_n;
  logic           hdr_ok;

  assign hdr_full = {hdr_q, mdio_i};
  assign op       = hdr_full[HW-1 -: 2];
  assign phy_n    = hdr_full[2*AW-1 -: AW];
  assign reg_n    = hdr_full[AW-1:0];
  assign hdr_ok   = strap_en && (phy_n[AW-1 -: BASE_W] == base) &&
                    (op == OP_RD || op == OP_WR);

  // write data is complete on the edge sampling the last data bit
  assign wr_en = (state == FS_DAT) && !is_rd && (cnt == DAT_LAST);
  assign wdata = {sh_q[DW-2:0], mdio_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= FS_PRE; pre_cnt <= '0; cnt <= '0; hdr_q <= '0; sh_q <= '0;
      is_rd <= 1'b0; phy_q <= '0; reg_q <= '0; mdio_o <= 1'b0; mdio_oe <= 1'b0;
    end else if (srst) begin
      state <= FS_PRE; pre_cnt <= '0; cnt <= '0; hdr_q <= '0; sh_q <= '0;
      is_rd <= 1'b0; phy_q <= '0; reg_q <= '0; mdio_o <= 1'b0; mdio_oe <= 1'b0;
    end else begin
      case (state)
        FS_PRE: begin
          if (mdio_i) begin
            if (pre_cnt != PRE_FULL) pre_cnt <= pre_cnt + 1'b1;
          end else begin
            if (pre_cnt == PRE_FULL) state <= FS_ST;
            pre_cnt <= '0;
          end
        end
        FS_ST: begin
          if (mdio_i) begin
            state <= FS_HDR;
            cnt   <= '0;
          end else begin
            state <= FS_PRE;
          end
        end
        FS_HDR: begin
          hdr_q <= hdr_full[HW-2:0];
          cnt   <= cnt + 1'b1;
          if (cnt == HDR_LAST) begin
            if (hdr_ok) begin
              state <= FS_TA1;
              is_rd <= (op == OP_RD);
              phy_q <= phy_n;
              reg_q <= reg_n;
            end else begin
              state <= FS_PRE;
            end
          end
        end
        FS_TA1: begin
          state <= FS_TA2;
          if (is_rd) begin
            mdio_oe <= 1'b1;
            mdio_o  <= 1'b0;
            sh_q    <= rdata;
          end
        end
        FS_TA2: begin
          state <= FS_DAT;
          cnt   <= '0;
          if (is_rd) begin
            mdio_o <= sh_q[DW-1];
            sh_q   <= {sh_q[DW-2:0], 1'b0};
          end
        end
        FS_DAT: begin
          cnt <= cnt + 1'b1;
          if (is_rd) begin
            if (cnt == DAT_LAST) begin
              mdio_oe <= 1'b0;
              mdio_o  <= 1'b0;
            end else begin
              mdio_o <= sh_q[DW-1];
              sh_q   <= {sh_q[DW-2:0], 1'b0};
            end
          end else begin
            sh_q <= wdata;
          end
          if (cnt == DAT_LAST) state <= FS_PRE;
        end
        default: state <= FS_PRE;
      endcase
    end
  end

  // R3: the first driven bit of a read turnaround is a zero
  assert_ta_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_o);

  // R3: the line is never driven while a write is being accepted
  assert_no_drive_on_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !mdio_oe);
endmodule

// File: rtl/mdio_chan_ctrl.sv
module mdio_chan_ctrl
  import mdio_bank_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          srst,
  input  logic          wr_en,
  input  logic          wr_loop,
  input  logic          wr_pd,
  input  logic          wr_iso,
  input  logic          ext_loop,
  output logic          loopback_o,
  output logic          pdown_o,
  output logic          isolate_o,
  output logic [DW-1:0] rd_val
);
  logic loop_q, pd_q, iso_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loop_q <= 1'b0; pd_q <= 1'b0; iso_q <= 1'b0;
    end else if (srst) begin
      loop_q <= 1'b0; pd_q <= 1'b0; iso_q <= 1'b0;
    end else if (wr_en) begin
      loop_q <= wr_loop; pd_q <= wr_pd; iso_q <= wr_iso;
    end
  end

  assign loopback_o = loop_q | ext_loop;
  assign pdown_o    = pd_q;
  assign isolate_o  = iso_q;

  always_comb begin
    rd_val         = CTRL_FIXED;
    rd_val[B_LOOP] = loop_q;
    rd_val[B_PD]   = pd_q;
    rd_val[B_ISO]  = iso_q;
  end

  // R6: power-down and isolate only move on a write or a reset
  assert_pd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !srst) |=> ($stable(pdown_o) && $stable(isolate_o)));
endmodule

// File: rtl/mdio_phy_bank.sv
module mdio_phy_bank
  import mdio_bank_pkg::*;
#(
  parameter int NCH     = 4,
  parameter int PRE_LEN = 32
) (
  input  logic           mdc,
  input  logic           rst_n,
  input  logic           cl22_sel,
  input  logic [2:0]     phy_base,
  input  logic           mdio_i,
  output logic           mdio_o,
  output logic           mdio_oe,
  input  logic [NCH-1:0] ext_loop_i,
  output logic [NCH-1:0] loopback_o,
  output logic [NCH-1:0] pdown_o,
  output logic [NCH-1:0] isolate_o,
  output logic           soft_rst_o
);
  localparam int CHW    = $clog2(NCH);
  localparam int BASE_W = AW - CHW;

  logic          wr_en;
  logic [DW-1:0] wdata;
  logic [AW-1:0] phy_q;
  logic [AW-1:0] reg_q;
  logic [DW-1:0] rd_mux;
  logic [DW-1:0] ch_rd [NCH];
  logic [CHW-1:0] ch_sel;
  logic          wr_ctrl;
  logic          srst_q;
  logic [DW-1:0] g0_q, g1_q;

  assign ch_sel  = phy_q[CHW-1:0];
  assign wr_ctrl = wr_en && (reg_q == REG_CTRL) && (int'(ch_sel) < NCH);

  mdio_frame_rx #(.PRE_LEN(PRE_LEN), .BASE_W(BASE_W)) u_frame (
    .clk(mdc), .rst_n(rst_n), .srst(srst_q), .strap_en(cl22_sel),
    .base(phy_base[BASE_W-1:0]), .mdio_i(mdio_i), .rdata(rd_mux),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .wr_en(wr_en), .wdata(wdata),
    .phy_q(phy_q), .reg_q(reg_q)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    mdio_chan_ctrl u_ch (
      .clk(mdc), .rst_n(rst_n), .srst(srst_q),
      .wr_en(wr_ctrl && (ch_sel == CHW'(i))),
      .wr_loop(wdata[B_LOOP]), .wr_pd(wdata[B_PD]), .wr_iso(wdata[B_ISO]),
      .ext_loop(ext_loop_i[i]), .loopback_o(loopback_o[i]),
      .pdown_o(pdown_o[i]), .isolate_o(isolate_o[i]), .rd_val(ch_rd[i])
    );
  end

  // soft reset: registered pulse, acts as synchronous clear one edge later
  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) srst_q <= 1'b0;
    else        srst_q <= wr_ctrl && wdata[B_RST];
  end
  assign soft_rst_o = srst_q;

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      g0_q <= '0; g1_q <= '0;
    end else if (srst_q) begin
      g0_q <= '0; g1_q <= '0;
    end else if (wr_en) begin
      if (reg_q == REG_G0) g0_q <= wdata;
      if (reg_q == REG_G1) g1_q <= wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (reg_q == REG_G0)      rd_mux = g0_q;
    else if (reg_q == REG_G1) rd_mux = g1_q;
    else if (reg_q == REG_CTRL && int'(ch_sel) < NCH) rd_mux = ch_rd[ch_sel];
  end

  // R8: the soft reset is a single-clock pulse
  assert_srst_pulse_R8: assert property (@(posedge mdc) disable iff (!rst_n)
    soft_rst_o |=> !soft_rst_o);

  // R8: after the pulse every channel control is clear
  assert_srst_clears_R8: assert property (@(posedge mdc) disable iff (!rst_n)
    soft_rst_o |=> (pdown_o == '0 && isolate_o == '0));

  // R2: an accepted write always carries the configured base
  assert_write_base_R2: assert property (@(posedge mdc) disable iff (!rst_n)
    wr_en |-> (phy_q[AW-1:CHW] == phy_base[BASE_W-1:0]));
endmodule

// File: tb/test_mdio_phy_bank.sv
`timescale 1ns/1ps
module test_mdio_phy_bank;
  logic       mdc = 1'b0;
  logic       rst_n = 1'b0;
  logic       cl22_sel = 1'b1;
  logic [2:0] phy_base = 3'b101;
  logic       mdio_i = 1'b0;
  logic [3:0] ext_loop_i = 4'b0000;
  logic       mdio_o, mdio_oe, soft_rst_o;
  logic [3:0] loopback_o, pdown_o, isolate_o;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #4 mdc = ~mdc;

  mdio_phy_bank i_mdio_phy_bank (
    .mdc(mdc), .rst_n(rst_n), .cl22_sel(cl22_sel), .phy_base(phy_base),
    .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .ext_loop_i(ext_loop_i), .loopback_o(loopback_o), .pdown_o(pdown_o),
    .isolate_o(isolate_o), .soft_rst_o(soft_rst_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] pa(input logic [2:0] b, input logic [1:0] ch);
    return {b, ch};
  endfunction

  task automatic send_bit(input logic b);
    @(negedge mdc);
    mdio_i = b;
  endtask

  // returns at the negedge after the edge that sampled the last data bit
  task automatic wr_frame(input int pre, input logic [4:0] p, input logic [4:0] r,
                          input logic [15:0] d);
    repeat (pre) send_bit(1'b1);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    for (int i = 4; i >= 0; i--) send_bit(p[i]);
    for (int i = 4; i >= 0; i--) send_bit(r[i]);
    send_bit(1'b1); send_bit(1'b0);
    for (int i = 15; i >= 0; i--) send_bit(d[i]);
    @(negedge mdc);
    mdio_i = 1'b0;
  endtask

  task automatic rd_frame(input int pre, input logic [4:0] p, input logic [4:0] r,
                          output logic [15:0] d, output logic drv, output logic quiet);
    d = '0; drv = 1'b1; quiet = 1'b1;
    repeat (pre) send_bit(1'b1);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    for (int i = 4; i >= 0; i--) send_bit(p[i]);
    for (int i = 4; i >= 0; i--) send_bit(r[i]);
    @(negedge mdc); mdio_i = 1'b1;
    if (mdio_oe) begin drv = 1'b0; quiet = 1'b0; end
    @(negedge mdc);
    if (!(mdio_oe && !mdio_o)) drv = 1'b0;
    if (mdio_oe) quiet = 1'b0;
    for (int i = 15; i >= 0; i--) begin
      @(negedge mdc);
      d[i] = mdio_o;
      if (!mdio_oe) drv = 1'b0; else quiet = 1'b0;
    end
    @(negedge mdc);
    if (mdio_oe) begin drv = 1'b0; quiet = 1'b0; end
    mdio_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] ch, input logic [4:0] r,
                        input logic [15:0] exp);
    logic [15:0] d; logic drv, quiet;
    rd_frame(32, pa(phy_base, ch), r, d, drv, quiet);
    chk(req, d, exp);
    chk("R3 read turnaround and data window", {15'd0, drv}, 16'd1);
  endtask

  task automatic t_reset();
    chk("R4 reset outputs", {4'd0, loopback_o, pdown_o, isolate_o}, 16'h0000);
    chk("R8 soft reset idle", {15'd0, soft_rst_o}, 16'd0);
    chk("R3 line released at reset", {15'd0, mdio_oe}, 16'd0);
    for (int c = 0; c < 4; c++) rd_chk("R4 control default", 2'(c), 5'd0, 16'h0140);
  endtask

  task automatic t_forced();
    wr_frame(32, pa(phy_base, 2'd1), 5'd0, 16'h7FFF);
    chk("R5 R6 ch1 outputs", {4'd0, loopback_o, pdown_o, isolate_o}, 16'h0222);
    rd_chk("R4 forced bits", 2'd1, 5'd0, 16'h4D40);
    rd_chk("R2 ch0 untouched", 2'd0, 5'd0, 16'h0140);
    wr_frame(32, pa(phy_base, 2'd1), 5'd0, 16'h0000);
    rd_chk("R4 cleared", 2'd1, 5'd0, 16'h0140);
  endtask

  task automatic t_chan_sel();
    wr_frame(32, pa(phy_base, 2'd2), 5'd0, 16'h0800);
    wr_frame(32, pa(phy_base, 2'd3), 5'd0, 16'h0400);
    chk("R2 R6 pdown per channel", {12'd0, pdown_o}, 16'h0004);
    chk("R2 R6 isolate per channel", {12'd0, isolate_o}, 16'h0008);
    rd_chk("R2 ch2 read", 2'd2, 5'd0, 16'h0940);
    rd_chk("R2 ch3 read", 2'd3, 5'd0, 16'h0540);
  endtask

  task automatic t_ext_loop();
    ext_loop_i = 4'b0001;
    @(negedge mdc);
    chk("R5 pin drives loopback", {12'd0, loopback_o}, 16'h0001);
    rd_chk("R5 pin not in readback", 2'd0, 5'd0, 16'h0140);
    wr_frame(32, pa(phy_base, 2'd0), 5'd0, 16'h4000);
    ext_loop_i = 4'b0000;
    @(negedge mdc);
    chk("R5 stored bit alone", {12'd0, loopback_o}, 16'h0001);
    rd_chk("R5 stored readback", 2'd0, 5'd0, 16'h4140);
    wr_frame(32, pa(phy_base, 2'd0), 5'd0, 16'h0000);
    chk("R5 loopback cleared", {12'd0, loopback_o}, 16'h0000);
  endtask

  task automatic t_global();
    wr_frame(32, pa(phy_base, 2'd0), 5'd30, 16'hA5C3);
    wr_frame(32, pa(phy_base, 2'd2), 5'd31, 16'h1234);
    rd_chk("R7 reg30 via ch3", 2'd3, 5'd30, 16'hA5C3);
    rd_chk("R7 reg31 via ch1", 2'd1, 5'd31, 16'h1234);
    wr_frame(32, pa(phy_base, 2'd3), 5'd30, 16'h5A3C);
    rd_chk("R7 reg30 rewrite via ch0", 2'd0, 5'd30, 16'h5A3C);
  endtask

  task automatic t_unimpl();
    wr_frame(32, pa(phy_base, 2'd0), 5'd5, 16'hFFFF);
    rd_chk("R9 unimplemented reads zero", 2'd0, 5'd5, 16'h0000);
    rd_chk("R9 control unaffected", 2'd0, 5'd0, 16'h0140);
    rd_chk("R9 reg31 unaffected", 2'd0, 5'd31, 16'h1234);
  endtask

  task automatic t_strap();
    logic [15:0] d; logic drv, quiet;
    cl22_sel = 1'b0;
    wr_frame(32, pa(phy_base, 2'd0), 5'd0, 16'h0800);
    rd_frame(32, pa(phy_base, 2'd0), 5'd0, d, drv, quiet);
    chk("R1 read silent without strap", {15'd0, quiet}, 16'd1);
    chk("R1 write ignored outputs", {12'd0, pdown_o}, 16'h0004);
    cl22_sel = 1'b1;
    rd_chk("R1 write ignored readback", 2'd0, 5'd0, 16'h0140);
  endtask

  task automatic t_base();
    logic [15:0] d; logic drv, quiet;
    wr_frame(32, pa(3'b100, 2'd0), 5'd0, 16'h0C00);
    chk("R2 foreign base write ignored", {4'd0, 4'd0, pdown_o, isolate_o}, 16'h0048);
    rd_frame(32, pa(3'b001, 2'd2), 5'd0, d, drv, quiet);
    chk("R2 foreign base read silent", {15'd0, quiet}, 16'd1);
    rd_chk("R2 ch0 unchanged", 2'd0, 5'd0, 16'h0140);
  endtask

  task automatic t_short_pre();
    logic [15:0] d; logic drv, quiet;
    wr_frame(31, pa(phy_base, 2'd1), 5'd0, 16'h0800);
    chk("R10 short preamble write ignored", {12'd0, pdown_o}, 16'h0004);
    rd_frame(31, pa(phy_base, 2'd1), 5'd0, d, drv, quiet);
    chk("R10 short preamble read silent", {15'd0, quiet}, 16'd1);
  endtask

  task automatic t_srst();
    wr_frame(32, pa(phy_base, 2'd2), 5'd0, 16'hC800);
    chk("R8 pulse high", {15'd0, soft_rst_o}, 16'd1);
    @(negedge mdc);
    chk("R8 pulse one clock", {15'd0, soft_rst_o}, 16'd0);
    chk("R8 outputs cleared", {4'd0, loopback_o, pdown_o, isolate_o}, 16'h0000);
    for (int c = 0; c < 4; c++) rd_chk("R8 control default", 2'(c), 5'd0, 16'h0140);
    rd_chk("R8 reg30 cleared", 2'd1, 5'd30, 16'h0000);
    rd_chk("R8 reg31 cleared", 2'd1, 5'd31, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge mdc);
    rst_n = 1'b1;
    @(negedge mdc);
    t_reset();
    t_forced();
    t_chan_sel();
    t_ext_loop();
    t_global();
    t_unimpl();
    t_strap();
    t_base();
    t_short_pre();
    t_srst();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge mdc);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule